// File: doc/BRIEF.md
# Gated Dual-Phase Frequency Counter

This block measures how often a digital input rises during fixed windows. It also builds its own timebase from the system clock. A down-counter divides the system clock to make a reference square wave (4096 Hz by default). That wave is divided again by a power of two to make a gate with a 50% duty cycle (1 Hz by default). A second down-counter makes a square wave at eight times a selectable serial bit rate. That wave is a known, local signal that can be fed back into the counter input to check the whole chain.

There are two accumulators. One counts while the gate is high and the other counts while it is low. The count taken in one half-period is shown at the output for the whole of the next half-period, so the shown value changes once per gate transition. A single incrementer serves both accumulators. It works either in packed BCD, ready for a decimal display, or in plain binary.

Top module: `freq_gate_counter`

## Requirements
- R1: While reset is asserted and on the first clock after it, `value`, `gate`, `ref_clk` and `baud_x8` are all 0.
- R2: `ref_clk` toggles once every CLK_HZ/(2·REF_HZ) clock cycles, with the first toggle exactly that many cycles after reset.
- R3: `gate` starts low and toggles on every 2^GATE_LOG2-th toggle of `ref_clk`, always on the same clock as a `ref_clk` toggle.
- R4: `sig_in` passes through a two-flip-flop synchroniser. Each low-to-high transition adds exactly one count, whatever the width of the pulse. A level that is held, high or low, adds nothing.
- R5: Each accumulator starts from zero in the first cycle of its own gate level. A rising edge detected in that cycle counts as 1.
- R6: While `gate` is high, `value` shows the count from the low phase just ended. While `gate` is low, it shows the count from the high phase just ended. It does not change within a gate level.
- R7: With `bcd_mode`=1 the count is packed BCD, least significant digit in bits [3:0]. A digit that would pass 9 becomes 0 and carries one into the next digit.
- R8: With `bcd_mode`=0 the count is an unsigned binary integer that wraps modulo 2^(4·DIGITS).
- R9: `baud_x8` toggles every max(1, CLK_HZ/(16·rate)) cycles. `rate_sel` value k selects rate = 600·2^k for k from 0 to 6, and k = 7 selects 57600. A new selection takes effect at the next toggle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sig_in | input | 1 | Signal whose rising edges are counted (asynchronous) |
| bcd_mode | input | 1 | 1 = packed BCD counting, 0 = binary counting |
| rate_sel | input | 3 | Bit-rate choice for `baud_x8` |
| value | output | 4·DIGITS | Count from the previous gate half-period |
| gate | output | 1 | Gate square wave that defines the counting windows |
| ref_clk | output | 1 | Reference square wave divided from `clk` |
| baud_x8 | output | 1 | Square wave at eight times the selected bit rate |

## Verification
The bench toggles the input on every clock so that each window holds about 256 edges. That count takes the BCD result across the 99-to-100 carry. A design with broken digit correction would show hex digits above 9. A design that resets the wrong accumulator at a gate change would show counts that are too large or that keep growing across windows. The bench also holds the input high for a whole run, where a level-counting design would report hundreds of edges instead of one. It feeds a pseudo-random input so that edges land on the cycle of a gate change, where a design that is one cycle off sends an edge to the wrong window. Finally it measures the half-period of `baud_x8` for every rate selection, which exposes a wrong reload table or an off-by-one reload.

// File: rtl/freq_gate_counter.sv
module freq_gate_counter #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int REF_HZ    = 4096,
  parameter int GATE_LOG2 = 12,
  parameter int DIGITS    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sig_in,
  input  logic                  bcd_mode,
  input  logic [2:0]            rate_sel,
  output logic [4*DIGITS-1:0]   value,
  output logic                  gate,
  output logic                  ref_clk,
  output logic                  baud_x8
);
  localparam int W = 4 * DIGITS;
  localparam logic [31:0] REF_RELOAD = 32'(CLK_HZ / (2 * REF_HZ) - 1);

  function automatic logic [31:0] baud_half(input logic [2:0] s);
    logic [31:0] rate, h;
    rate = (s == 3'd7) ? 32'd57600 : (32'd600 << s);
    h = 32'(CLK_HZ) / (32'd16 * rate);
    return (h == 32'd0) ? 32'd1 : h;
  endfunction

  function automatic logic [W-1:0] add_one(input logic [W-1:0] a, input logic bcd);
    logic [W-1:0] r;
    logic [4:0] d;
    logic c;
    if (!bcd) return a + 1'b1;
    c = 1'b1;
    r = '0;
    for (int i = 0; i < DIGITS; i++) begin
      d = {1'b0, a[4*i +: 4]} + {4'd0, c};
      if (d > 5'd9) begin
        d = d + 5'd6;
        c = 1'b1;
      end else begin
        c = 1'b0;
      end
      r[4*i +: 4] = d[3:0];
    end
    return r;
  endfunction

  logic [31:0]        ref_cnt, baud_cnt;
  logic [GATE_LOG2:0] gate_cnt;
  logic [2:0]         sync;
  logic               gate_d;
  logic [W-1:0]       acc_hi, acc_lo, active, next_val;
  logic               hit, ref_tick, phase_start;

  assign ref_tick    = (ref_cnt == 32'd0);
  assign hit         = sync[1] & ~sync[2];
  assign gate        = gate_cnt[GATE_LOG2];
  assign phase_start = gate ^ gate_d;
  assign active      = gate ? acc_hi : acc_lo;
  assign next_val    = phase_start ? W'(hit) : (hit ? add_one(active, bcd_mode) : active);
  assign value       = gate ? acc_lo : acc_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync     <= '0;
      gate_d   <= 1'b0;
      ref_cnt  <= REF_RELOAD;
      ref_clk  <= 1'b0;
      gate_cnt <= '0;
      baud_cnt <= '0;
      baud_x8  <= 1'b0;
      acc_hi   <= '0;
      acc_lo   <= '0;
    end else begin
      sync   <= {sync[1:0], sig_in};
      gate_d <= gate;
      if (ref_tick) begin
        ref_cnt  <= REF_RELOAD;
        ref_clk  <= ~ref_clk;
        gate_cnt <= gate_cnt + 1'b1;
      end else begin
        ref_cnt <= ref_cnt - 1'b1;
      end
      if (baud_cnt == 32'd0) begin
        baud_cnt <= baud_half(rate_sel) - 1'b1;
        baud_x8  <= ~baud_x8;
      end else begin
        baud_cnt <= baud_cnt - 1'b1;
      end
      if (gate) acc_hi <= next_val;
      else      acc_lo <= next_val;
    end
  end

  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !gate_d) |=> (acc_hi <= W'(1))); // R5

  AST_SHOWN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (gate == gate_d) |=> (gate != $past(gate) || $stable(value))); // R6

  AST_GATE_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(gate) |-> $changed(ref_clk)); // R3

  AST_SINGLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit); // R4
endmodule

// File: tb/tb_freq_gate_counter.sv
module tb_freq_gate_counter;
  localparam int CLK_PERIOD = 10;
  localparam int CHZ = 2097152;
  localparam int RHZ = 4096;
  localparam int GL2 = 1;
  localparam int H   = CHZ / (2 * RHZ);
  localparam int GH  = H * (1 << GL2);

  logic clk = 1'b0, rst_n = 1'b0, sig = 1'b0, bcd = 1'b1;
  logic [2:0] sel = 3'd0;
  logic [31:0] value;
  logic gate, ref_clk, baud_x8;

  freq_gate_counter #(.CLK_HZ(CHZ), .REF_HZ(RHZ), .GATE_LOG2(GL2), .DIGITS(8)) dut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig), .bcd_mode(bcd), .rate_sel(sel),
    .value(value), .gate(gate), .ref_clk(ref_clk), .baud_x8(baud_x8));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  int n = 0, m_hi = 0, m_lo = 0, c = 0, lfsr = 1;
  int cur_pattern = 0, rst_cycles = 3;
  bit cur_bcd = 1'b1;
  logic [2:0] cur_sel = 3'd0;
  bit q1, q2, q3;

  function automatic int gate_at(input int k);
    return (k / GH) % 2;
  endfunction

  function automatic logic [31:0] enc(input int cnt, input bit b);
    logic [31:0] r;
    int v;
    if (!b) return 32'(cnt);
    v = cnt;
    r = '0;
    for (int i = 0; i < 8; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      n = 0; m_hi = 0; m_lo = 0; q1 = 0; q2 = 0; q3 = 0;
    end else begin
      int e, g, gd;
      e  = (q2 && !q3) ? 1 : 0;
      g  = gate_at(n);
      gd = (n > 0) ? gate_at(n - 1) : 0;
      if (g == 1) m_hi = (g != gd) ? e : m_hi + e;
      else        m_lo = (g != gd) ? e : m_lo + e;
      q3 = q2; q2 = q1; q1 = sig;
      n++;
    end
  end

  always @(negedge clk) begin
    logic [31:0] ev;
    ev = (gate_at(n) == 1) ? enc(m_lo, bcd) : enc(m_hi, bcd);
    if (!rst_n) begin
      check(value == 32'd0 && gate == 1'b0 && ref_clk == 1'b0 && baud_x8 == 1'b0,
            "R1 reset outputs", {value[28:0], gate, ref_clk, baud_x8}, 32'd0);
    end else begin
      check(value == ev, bcd ? "R6 value bcd (R4 R5 R7)" : "R6 value binary (R4 R5 R8)", value, ev);
      check(gate == 1'(gate_at(n)), "R3 gate level", 32'(gate), 32'(gate_at(n)));
      check(ref_clk == 1'((n / H) % 2), "R2 ref_clk level", 32'(ref_clk), 32'((n / H) % 2));
    end
    sel = cur_sel;
    if (rst_cycles > 0) begin
      rst_cycles--;
      rst_n = 1'b0; sig = 1'b0; c = 0; bcd = cur_bcd;
    end else begin
      rst_n = 1'b1;
      c++;
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      case (cur_pattern)
        0: sig = 1'b0;
        1: sig = ~sig;
        2: sig = ((c % 7) < 3);
        3: sig = lfsr[0];
        default: sig = 1'b1;
      endcase
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int b = 1; b >= 0; b--) begin
      for (int p = 0; p < 5; p++) begin
        @(posedge clk);
        cur_bcd = 1'(b); cur_pattern = p; rst_cycles = 3;
        repeat (4 * GH + 8) @(posedge clk);
      end
    end
    for (int s = 0; s < 8; s++) begin
      int rate, hexp, cnt;
      logic prev;
      rate = (s == 7) ? 57600 : 600 * (1 << s);
      hexp = CHZ / (16 * rate);
      if (hexp < 1) hexp = 1;
      cur_sel = 3'(s);
      repeat (3) begin
        @(negedge clk); prev = baud_x8;
        while (baud_x8 == prev) @(negedge clk);
      end
      prev = baud_x8; cnt = 0;
      while (baud_x8 == prev) begin @(negedge clk); cnt++; end
      check(cnt == hexp, "R9 baud_x8 half period", 32'(cnt), 32'(hexp));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule